// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block turns eight input pins, which may change at any time relative to the clock, into eight interrupt request lines. Each pin is resynchronised, then watched for rising and falling transitions. Every transition is recorded in a sticky per-channel bit whatever the enables say. Each channel is set up to work in one of two ways. An edge channel requests while an enabled edge bit is set. A level channel requests while the pin sits at its chosen active level.

Software reaches all state through a plain register port. It has a word address, a write strobe, 32-bit write data and read data that is registered one cycle. The status register is written in two ways, chosen per channel by its mode. For an edge channel a one clears both recorded edges. For a level channel a one flips the active level, which lets a handler re-arm on the opposite level. A control bit hands the request lines over to an external pattern-match result bus. A second control bit lets any pattern match drive a single event output.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, and so do `irq_o` and `event_o`. The register map is: 0 mode (1 = level), 1 rise enable, 2 fall enable, 3 level enable, 4 active level (1 = high), 5 rise latch, 6 fall latch, 7 status, 8 control (bit0 pattern select, bit1 event enable). Bits above the channel field (above bit 1 for control) read zero and ignore writes. Unmapped addresses read zero.
- R2: A rise latch bit becomes 1 three clock edges after its pin goes high, and then stays set. Writing a one to that bit at address 5 clears it. Writing a zero has no effect.
- R3: The fall latch at address 6 behaves the same way for a pin going low.
- R4: Edges are latched whatever the state of the enable bits and the mode.
- R5: An edge channel (mode bit 0) requests when the channel's rise latch and rise enable are both set, or when its fall latch and fall enable are both set.
- R6: A level channel (mode bit 1) requests when its level enable is set and its synchronised pin equals its active-level bit. The request follows the pin two clock edges after the pin changes.
- R7: Reading status (address 7) returns a one for each channel whose pin logic is requesting.
- R8: Writing a one to status bit n of an edge channel clears both its rise and fall latches.
- R9: Writing a one to status bit n of a level channel inverts its active-level bit.
- R10: When a latch clear and a new edge on the same channel fall in the same cycle, the latch stays set.
- R11: When control bit0 is 1, `irq_o` equals `pm_match_i`; when it is 0, `irq_o` carries the pin requests. `event_o` is control bit1 ANDed with the OR of `pm_match_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | 8 | Selected pins, asynchronous |
| pm_match_i | input | 8 | Pattern-match results, synchronous |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 8 | Per-channel interrupt request |
| event_o | output | 1 | Pattern-match event to the CPU |

## Verification
The assertions assume that `pm_match_i` and the bus inputs are synchronous to `clk`. Only the pins are free to change at any moment. The bench drives every input on the falling clock edge, so none of them moves near a sampling edge. It holds each pin level for at least four cycles, so every transition passes through the synchroniser and the edge compare before the latches are read.

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic [NCH-1:0] pm_match_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           we_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  output logic [NCH-1:0] irq_o,
  output logic           event_o
);
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_REN  = AW'(1);
  localparam logic [AW-1:0] A_FEN  = AW'(2);
  localparam logic [AW-1:0] A_LEN  = AW'(3);
  localparam logic [AW-1:0] A_LVL  = AW'(4);
  localparam logic [AW-1:0] A_RL   = AW'(5);
  localparam logic [AW-1:0] A_FL   = AW'(6);
  localparam logic [AW-1:0] A_ST   = AW'(7);
  localparam logic [AW-1:0] A_CTL  = AW'(8);

  logic [NCH-1:0] sync1, sync2, prev;
  logic [NCH-1:0] mode, ren, fen, len, lvl, rlat, flat;
  logic           pm_sel, ev_en;
  logic [NCH-1:0] wr, rise, fall, edge_req, lvl_req, pin_req;
  logic [NCH-1:0] rl_clr, fl_clr;
  logic [31:0]    rd_next;
  logic           unused_hi;

  assign wr        = wdata_i[NCH-1:0];
  assign unused_hi = ^wdata_i;
  assign rise      = sync2 & ~prev;
  assign fall      = ~sync2 & prev;
  assign edge_req  = (rlat & ren) | (flat & fen);
  assign lvl_req   = len & ~(sync2 ^ lvl);
  assign pin_req   = (mode & lvl_req) | (~mode & edge_req);
  assign irq_o     = pm_sel ? pm_match_i : pin_req;
  assign event_o   = ev_en & (|pm_match_i);

  wire wr_st = we_i && addr_i == A_ST;
  assign rl_clr = ((we_i && addr_i == A_RL) ? wr : '0) | (wr_st ? (wr & ~mode) : '0);
  assign fl_clr = ((we_i && addr_i == A_FL) ? wr : '0) | (wr_st ? (wr & ~mode) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      ren    <= '0;
      fen    <= '0;
      len    <= '0;
      lvl    <= '0;
      rlat   <= '0;
      flat   <= '0;
      pm_sel <= 1'b0;
      ev_en  <= 1'b0;
    end else begin
      rlat <= (rlat & ~rl_clr) | rise;
      flat <= (flat & ~fl_clr) | fall;
      if (we_i) begin
        case (addr_i)
          A_MODE: mode <= wr;
          A_REN:  ren  <= wr;
          A_FEN:  fen  <= wr;
          A_LEN:  len  <= wr;
          A_LVL:  lvl  <= wr;
          A_ST:   lvl  <= lvl ^ (wr & mode);
          A_CTL:  {ev_en, pm_sel} <= wdata_i[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_i)
      A_MODE: rd_next[NCH-1:0] = mode;
      A_REN:  rd_next[NCH-1:0] = ren;
      A_FEN:  rd_next[NCH-1:0] = fen;
      A_LEN:  rd_next[NCH-1:0] = len;
      A_LVL:  rd_next[NCH-1:0] = lvl;
      A_RL:   rd_next[NCH-1:0] = rlat;
      A_FL:   rd_next[NCH-1:0] = flat;
      A_ST:   rd_next[NCH-1:0] = pin_req;
      A_CTL:  rd_next[1:0]     = {ev_en, pm_sel};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_next;
  end
endmodule

module pin_irq_ctrl_chk #(
  parameter int NCH = 8,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  addr_i,
  input logic           we_i,
  input logic [31:0]    wdata_i,
  input logic [31:0]    rdata_o,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] mode,
  input logic [NCH-1:0] ren,
  input logic [NCH-1:0] fen,
  input logic [NCH-1:0] lvl,
  input logic [NCH-1:0] rlat,
  input logic [NCH-1:0] flat,
  input logic [NCH-1:0] sync2,
  input logic [NCH-1:0] prev,
  input logic           pm_sel
);
  localparam logic [AW-1:0] C_LVL = AW'(4);
  localparam logic [AW-1:0] C_RL  = AW'(5);
  localparam logic [AW-1:0] C_FL  = AW'(6);
  localparam logic [AW-1:0] C_ST  = AW'(7);

  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o >> NCH) == 32'd0);

  a_r2_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && (addr_i == C_RL || addr_i == C_ST)) |=> (($past(rlat) & ~rlat) == '0));

  a_r3_fall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && (addr_i == C_FL || addr_i == C_ST)) |=> (($past(flat) & ~flat) == '0));

  // R10: a fresh rising edge always lands in the latch, clear or not
  a_r4_rise_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sync2 & ~prev)) |=> (($past(sync2 & ~prev) & ~rlat) == '0));

  a_r5_edge_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_sel |-> ((irq_o & ~mode & ~((rlat & ren) | (flat & fen))) == '0));

  a_r9_level_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == C_ST) |=> lvl == ($past(lvl) ^ ($past(wdata_i[NCH-1:0]) & $past(mode))));

  a_r9_lvl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && (addr_i == C_ST || addr_i == C_LVL)) |=> $stable(lvl));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .mode(mode), .ren(ren), .fen(fen),
  .lvl(lvl), .rlat(rlat), .flat(flat), .sync2(sync2), .prev(prev), .pm_sel(pm_sel)
);

// File: tb/test_pin_irq_ctrl.sv
`timescale 1ns/1ps
module test_pin_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_i = '0;
  logic [7:0]  pm_match_i = '0;
  logic [3:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  irq_o;
  logic        event_o;
  int nchk = 0;
  int nerr = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  pin_irq_ctrl i_pin_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pm_match_i(pm_match_i),
    .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .event_o(event_o)
  );

  typedef struct packed {
    logic [3:0]  a;
    logic        w;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{4'd0, 1'b1, 32'hFFFF_FFA5, 32'h0},
    '{4'd0, 1'b0, 32'h0,         32'h0000_00A5},
    '{4'd1, 1'b1, 32'h1234_563C, 32'h0},
    '{4'd1, 1'b0, 32'h0,         32'h0000_003C},
    '{4'd4, 1'b1, 32'h0000_01FF, 32'h0},
    '{4'd4, 1'b0, 32'h0,         32'h0000_00FF},
    '{4'd8, 1'b1, 32'hFFFF_FFFF, 32'h0},
    '{4'd8, 1'b0, 32'h0,         32'h0000_0003},
    '{4'd15,1'b1, 32'hFFFF_FFFF, 32'h0},
    '{4'd15,1'b0, 32'h0,         32'h0},
    '{4'd0, 1'b1, 32'h0,         32'h0},
    '{4'd1, 1'b1, 32'h0,         32'h0},
    '{4'd4, 1'b1, 32'h0,         32'h0},
    '{4'd8, 1'b1, 32'h0,         32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; we_i = 1'b1; wdata_i = d;
    @(posedge clk); #1;
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a; we_i = 1'b0;
    @(posedge clk); #1;
    d = rdata_o;
  endtask

  task automatic setpins(input logic [7:0] p);
    @(negedge clk);
    pin_i = p;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    #1;
    chk("R1 irq", {24'h0, irq_o}, 32'h0);
    chk("R1 event", {31'h0, event_o}, 32'h0);
    rd(4'd7, rv); chk("R1 status", rv, 32'h0);
    rd(4'd0, rv); chk("R1 mode", rv, 32'h0);

    // R1 register table
    for (int i = 0; i < NV; i++) begin
      if (VT[i].w) wr(VT[i].a, VT[i].d);
      else begin
        rd(VT[i].a, rv);
        chk("R1 table", rv, VT[i].e);
      end
    end

    // R2 R4 rising edge on ch0 with enables off
    setpins(8'h01);
    rd(4'd5, rv); chk("R2 rise latch", rv, 32'h01);
    rd(4'd6, rv); chk("R3 no fall", rv, 32'h00);
    chk("R4 no irq when disabled", {24'h0, irq_o}, 32'h0);
    rd(4'd7, rv); chk("R7 status idle", rv, 32'h0);
    wr(4'd1, 32'h01);
    chk("R5 rise irq", {24'h0, irq_o}, 32'h01);
    rd(4'd7, rv); chk("R7 status req", rv, 32'h01);
    wr(4'd5, 32'h00);
    rd(4'd5, rv); chk("R2 zero write no effect", rv, 32'h01);
    wr(4'd5, 32'h01);
    rd(4'd5, rv); chk("R2 w1c", rv, 32'h00);
    chk("R5 irq drops", {24'h0, irq_o}, 32'h0);

    // R3 falling edge
    setpins(8'h00);
    rd(4'd6, rv); chk("R3 fall latch", rv, 32'h01);
    wr(4'd2, 32'h01);
    chk("R5 fall irq", {24'h0, irq_o}, 32'h01);
    wr(4'd7, 32'h01);
    rd(4'd6, rv); chk("R8 status clears fall", rv, 32'h00);
    chk("R8 irq cleared", {24'h0, irq_o}, 32'h0);

    // R8 both latches on ch1
    setpins(8'h02);
    setpins(8'h00);
    rd(4'd5, rv); chk("R2 ch1 rise", rv, 32'h02);
    rd(4'd6, rv); chk("R3 ch1 fall", rv, 32'h02);
    wr(4'd7, 32'h00);
    rd(4'd5, rv); chk("R8 zero write keeps", rv, 32'h02);
    wr(4'd7, 32'h02);
    rd(4'd5, rv); chk("R8 rise cleared", rv, 32'h00);
    rd(4'd6, rv); chk("R8 fall cleared", rv, 32'h00);

    // R10 clear coincident with new rising edge on ch0
    setpins(8'h01);
    setpins(8'h00);
    rd(4'd5, rv); chk("R10 pre set", rv, 32'h01);
    @(negedge clk) pin_i = 8'h01;
    @(posedge clk); @(posedge clk);
    wr(4'd5, 32'h01);
    rd(4'd5, rv); chk("R10 edge wins", rv, 32'h01);
    wr(4'd5, 32'hFF); wr(4'd6, 32'hFF);
    setpins(8'h00);
    wr(4'd6, 32'hFF);
    wr(4'd1, 32'h00); wr(4'd2, 32'h00);

    // R6 R9 level channel 4
    wr(4'd0, 32'h10); wr(4'd3, 32'h10); wr(4'd4, 32'h10);
    chk("R6 level idle", {24'h0, irq_o}, 32'h00);
    @(negedge clk) pin_i = 8'h10;
    @(posedge clk); @(posedge clk); #1;
    chk("R6 level high req", {24'h0, irq_o}, 32'h10);
    rd(4'd7, rv); chk("R7 level status", rv, 32'h10);
    wr(4'd7, 32'h10);
    rd(4'd4, rv); chk("R9 level toggled", rv, 32'h00);
    chk("R9 irq off after toggle", {24'h0, irq_o}, 32'h00);
    setpins(8'h00);
    chk("R6 active low req", {24'h0, irq_o}, 32'h10);

    // R11 pattern-match routing and event
    pm_match_i = 8'h81;
    wr(4'd8, 32'h01);
    chk("R11 routed", {24'h0, irq_o}, 32'h81);
    chk("R11 event off", {31'h0, event_o}, 32'h0);
    wr(4'd8, 32'h03);
    chk("R11 event on", {31'h0, event_o}, 32'h1);
    @(negedge clk) pm_match_i = 8'h00; #1;
    chk("R11 event idle", {31'h0, event_o}, 32'h0);
    wr(4'd8, 32'h00);
    chk("R11 pin view back", {24'h0, irq_o}, 32'h10);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule